// File: doc/BRIEF.md
# Skid-Buffered Rename-to-ROB Intake

This block sits between the rename stage and the reorder buffer. Each cycle rename presents a bundle of up to `LANES` instruction slots. Every slot carries a valid bit, a squashed bit and a tag payload. The block hands up to `LANES` instructions per cycle to the ROB. When commit cannot accept the full flow, the surplus is held in a FIFO skid buffer and released later. Held instructions always go out ahead of newer arrivals, so program order is preserved.

A slot counts as live when its valid bit is 1 and its squashed bit is 0. Live slots are packed toward lane 0 in their original lane order. Non-live slots are dropped outright: they are never forwarded and never stored. On a stall cycle nothing is forwarded and every live slot is stored. A flush empties the skid buffer in one cycle. When the buffer has less room than one bundle it raises a full flag, so that rename can hold off. A push that still does not fit is clipped and latches an error flag.

The output path is combinational from the inputs and the skid state. Only the skid buffer, its pointers and the error flag are registered. `DEPTH` must be a power of two and at least `LANES`.

Top module: `rn_skid_intake`

## Requirements
- R1: During and right after reset, with no live input, `out_valid` is 0, `skid_full` is 0 and `ovf_err` is 0, and the skid buffer is empty.
- R2: On a cycle with neither stall nor flush, the number of forwarded instructions is min(`LANES`, skid occupancy + live incoming count).
- R3: Forwarded instructions fill lanes 0 upward with no gaps (`out_valid` is a low-order run of ones). Skid entries come first in FIFO order, then live incoming slots in ascending lane order.
- R4: Live incoming slots that find no free output lane are written into the skid buffer in ascending lane order. They are forwarded on later cycles ahead of any newer arrival.
- R5: A slot with valid=0 or squashed=1 is neither forwarded nor stored.
- R6: While `stall` is 1 and `flush` is 0, `out_valid` is 0 and every live incoming slot is appended to the skid buffer.
- R7: While `flush` is 1, `out_valid` is 0 and the incoming bundle is discarded. From the next cycle the skid buffer is empty.
- R8: `skid_full` is 1 exactly when `DEPTH` minus occupancy is less than `LANES`.
- R9: A push that exceeds the free space stores only the leading slots that fit and drops the rest. From the next cycle `ovf_err` is 1, and it stays 1, through flushes too, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard the bundle and empty the skid buffer |
| stall | input | 1 | Commit not accepting: forward nothing, store the bundle |
| in_valid | input | LANES | Per-slot valid bit, lane 0 oldest |
| in_squash | input | LANES | Per-slot squashed bit |
| in_tag | input | LANES*TAG_W | Slot payloads, lane i at bits [i*TAG_W +: TAG_W] |
| out_valid | output | LANES | Forwarded-lane mask, always a low-order run of ones |
| out_tag | output | LANES*TAG_W | Forwarded payloads, lane 0 oldest |
| skid_full | output | 1 | Free space is below one bundle |
| ovf_err | output | 1 | Sticky: a push was clipped for lack of space |

## Verification
The assertions assume that `flush` and `stall` are driven as clean levels for a whole cycle. They also assume that rename may keep presenting bundles while `skid_full` is high, which is what allows the overflow case to be reached on purpose. The stimulus changes inputs only shortly after a rising edge and holds them to the next edge. It drives a known idle bundle during reset, so the combinational output path never sees undefined slot bits while an assertion is active. Overflow is provoked only in one directed sequence that fills the buffer by stalling, and reset then clears the sticky flag.

// File: rtl/skid_intake_pkg.sv
package skid_intake_pkg;

  // smaller of two counts
  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // instructions forwarded on an unstalled cycle
  function automatic int fwd_total(input int lanes, input int held, input int arriving);
    return min_int(lanes, held + arriving);
  endfunction

  // free skid slots once this cycle's pops are taken out
  function automatic int room_after(input int depth, input int held, input int popped);
    return depth - held + popped;
  endfunction

  // full when less than one bundle of room remains
  function automatic logic short_of_room(input int depth, input int held, input int lanes);
    return (depth - held) < lanes;
  endfunction

endpackage

// File: rtl/intake_compact.sv
module intake_compact #(
  parameter int LANES = 4,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]       valid,
  input  logic [LANES-1:0]       squash,
  input  logic [LANES*TAG_W-1:0] tag_flat,
  output logic [LANES*TAG_W-1:0] live_flat,
  output logic [IDX_W-1:0]       live_cnt
);

  // pack live slots toward lane 0, keeping their lane order
  always_comb begin
    int k;
    k = 0;
    live_flat = '0;
    for (int i = 0; i < LANES; i++) begin
      if (valid[i] && !squash[i]) begin
        live_flat[k*TAG_W +: TAG_W] = tag_flat[i*TAG_W +: TAG_W];
        k = k + 1;
      end
    end
    live_cnt = IDX_W'(k);
  end

endmodule

// File: rtl/intake_merge.sv
module intake_merge
  import skid_intake_pkg::*;
#(
  parameter int LANES = 4,
  parameter int TAG_W = 8,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(LANES + 1),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stall,
  input  logic                   flush,
  input  logic [CNT_W-1:0]       held_cnt,
  input  logic [LANES*TAG_W-1:0] head_flat,
  input  logic [LANES*TAG_W-1:0] live_flat,
  input  logic [IDX_W-1:0]       live_cnt,
  output logic [LANES-1:0]       out_valid,
  output logic [LANES*TAG_W-1:0] out_tag,
  output logic [IDX_W-1:0]       pop_cnt,
  output logic [IDX_W-1:0]       push_cnt,
  output logic [LANES*TAG_W-1:0] push_flat
);

  always_comb begin
    int held, arr, tot, pops, taken;
    held = int'(held_cnt);
    arr  = int'(live_cnt);
    tot = 0; pops = 0; taken = 0;
    out_valid = '0;
    out_tag   = '0;
    pop_cnt   = '0;
    push_cnt  = '0;
    push_flat = '0;
    if (flush) begin
      // everything this cycle is dropped
    end else if (stall) begin
      push_cnt  = live_cnt;
      push_flat = live_flat;
    end else begin
      tot   = fwd_total(LANES, held, arr);
      pops  = min_int(held, LANES);
      taken = tot - pops;
      for (int i = 0; i < LANES; i++) begin
        if (i < tot) begin
          out_valid[i] = 1'b1;
          if (i < pops) out_tag[i*TAG_W +: TAG_W] = head_flat[i*TAG_W +: TAG_W];
          else          out_tag[i*TAG_W +: TAG_W] = live_flat[(i-pops)*TAG_W +: TAG_W];
        end
      end
      for (int j = 0; j < LANES; j++) begin
        if (j + taken < arr)
          push_flat[j*TAG_W +: TAG_W] = live_flat[(j+taken)*TAG_W +: TAG_W];
      end
      pop_cnt  = IDX_W'(pops);
      push_cnt = IDX_W'(arr - taken);
    end
  end

  // R6
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (out_valid == '0));

  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (out_valid == '0 && push_cnt == '0));

  // R3
  prefix_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid + LANES'(1)) & out_valid) == '0);

  // R2
  pop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_cnt) <= int'(held_cnt));

endmodule

// File: rtl/intake_fifo.sv
module intake_fifo
  import skid_intake_pkg::*;
#(
  parameter int LANES = 4,
  parameter int TAG_W = 8,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(LANES + 1),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [IDX_W-1:0]       pop_cnt,
  input  logic [IDX_W-1:0]       push_cnt,
  input  logic [LANES*TAG_W-1:0] push_flat,
  output logic [LANES*TAG_W-1:0] head_flat,
  output logic [CNT_W-1:0]       held_cnt,
  output logic                   full,
  output logic                   ovf_err
);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] accept_cnt;
  logic             ovf_now;

  always_comb begin
    int room;
    room       = room_after(DEPTH, int'(count), int'(pop_cnt));
    accept_cnt = IDX_W'(min_int(int'(push_cnt), room));
    ovf_now    = (int'(push_cnt) > room);
  end

  assign full     = short_of_room(DEPTH, int'(count), LANES);
  assign held_cnt = count;

  for (genvar g = 0; g < LANES; g++) begin : g_head
    assign head_flat[g*TAG_W +: TAG_W] = mem[rd_ptr + PTR_W'(g)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count   <= '0;
      ovf_err <= 1'b0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_ptr + PTR_W'(pop_cnt);
      wr_ptr <= wr_ptr + PTR_W'(accept_cnt);
      count  <= count - CNT_W'(pop_cnt) + CNT_W'(accept_cnt);
      if (ovf_now) ovf_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int j = 0; j < LANES; j++) begin
        if (j < int'(accept_cnt))
          mem[wr_ptr + PTR_W'(j)] <= push_flat[j*TAG_W +: TAG_W];
      end
    end
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R9
  clip_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && int'(push_cnt) > int'(accept_cnt)) |=> ovf_err);

endmodule

// File: rtl/rn_skid_intake.sv
module rn_skid_intake #(
  parameter int LANES = 4,
  parameter int TAG_W = 8,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(LANES + 1),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   stall,
  input  logic [LANES-1:0]       in_valid,
  input  logic [LANES-1:0]       in_squash,
  input  logic [LANES*TAG_W-1:0] in_tag,
  output logic [LANES-1:0]       out_valid,
  output logic [LANES*TAG_W-1:0] out_tag,
  output logic                   skid_full,
  output logic                   ovf_err
);

  logic [LANES*TAG_W-1:0] live_flat, head_flat, push_flat;
  logic [IDX_W-1:0]       live_cnt, pop_cnt, push_cnt;
  logic [CNT_W-1:0]       held_cnt;

  intake_compact #(.LANES(LANES), .TAG_W(TAG_W)) compact_i (
    .valid(in_valid), .squash(in_squash), .tag_flat(in_tag),
    .live_flat(live_flat), .live_cnt(live_cnt)
  );

  intake_merge #(.LANES(LANES), .TAG_W(TAG_W), .DEPTH(DEPTH)) merge_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .flush(flush),
    .held_cnt(held_cnt), .head_flat(head_flat),
    .live_flat(live_flat), .live_cnt(live_cnt),
    .out_valid(out_valid), .out_tag(out_tag),
    .pop_cnt(pop_cnt), .push_cnt(push_cnt), .push_flat(push_flat)
  );

  intake_fifo #(.LANES(LANES), .TAG_W(TAG_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .pop_cnt(pop_cnt), .push_cnt(push_cnt), .push_flat(push_flat),
    .head_flat(head_flat), .held_cnt(held_cnt),
    .full(skid_full), .ovf_err(ovf_err)
  );

endmodule

// File: tb/rn_skid_intake_tb_top.sv
`timescale 1ns/1ps
module rn_skid_intake_tb_top;

  localparam int LANES = 4;
  localparam int TAG_W = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, stall = 1'b0;
  logic [LANES-1:0] in_valid = '0, in_squash = '0;
  logic [LANES*TAG_W-1:0] in_tag = '0;
  logic [LANES-1:0] out_valid;
  logic [LANES*TAG_W-1:0] out_tag;
  logic skid_full, ovf_err;

  always #5 clk = ~clk;

  rn_skid_intake #(.LANES(LANES), .TAG_W(TAG_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .stall(stall),
    .in_valid(in_valid), .in_squash(in_squash), .in_tag(in_tag),
    .out_valid(out_valid), .out_tag(out_tag),
    .skid_full(skid_full), .ovf_err(ovf_err)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] q[$];
  bit merr = 0;

  // {stall, flush, valid[3:0], squash[3:0], base tag, expected forward count}
  localparam logic [20:0] VEC [0:9] = '{
    {1'b0, 1'b0, 4'b1111, 4'b0000, 8'h10, 3'd4},
    {1'b0, 1'b0, 4'b0101, 4'b0000, 8'h20, 3'd2},
    {1'b1, 1'b0, 4'b1111, 4'b0000, 8'h30, 3'd0},
    {1'b0, 1'b0, 4'b0011, 4'b0000, 8'h40, 3'd4},
    {1'b0, 1'b0, 4'b1111, 4'b0110, 8'h50, 3'd4},
    {1'b1, 1'b0, 4'b1111, 4'b1000, 8'h60, 3'd0},
    {1'b1, 1'b0, 4'b1111, 4'b0000, 8'h70, 3'd0},
    {1'b0, 1'b0, 4'b0000, 4'b0000, 8'h00, 3'd4},
    {1'b0, 1'b0, 4'b1000, 4'b0000, 8'h80, 3'd4},
    {1'b0, 1'b0, 4'b1111, 4'b1111, 8'h90, 3'd0}
  };

  function automatic string req_of(input int idx);
    case (idx)
      0: return "R2";
      1: return "R3";
      2: return "R6";
      3: return "R4";
      4: return "R5";
      5: return "R5";
      6: return "R6";
      7: return "R3";
      8: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive, compare against the queue model, then advance it
  task automatic step(input bit st, input bit fl, input logic [3:0] v,
                      input logic [3:0] s, input logic [7:0] base,
                      input int exp_cnt, input string req);
    logic [7:0] live[$];
    logic [7:0] seq[$];
    logic [LANES-1:0] ev;
    logic [LANES*TAG_W-1:0] et;
    int tot, pops, taken, room;
    @(posedge clk); #1;
    stall = st; flush = fl; in_valid = v; in_squash = s;
    for (int i = 0; i < LANES; i++) in_tag[i*TAG_W +: TAG_W] = base + 8'(i);
    #2;
    for (int i = 0; i < LANES; i++) if (v[i] && !s[i]) live.push_back(base + 8'(i));
    ev = '0; et = '0; tot = 0; pops = 0;
    if (!fl && !st) begin
      seq = q;
      foreach (live[k]) seq.push_back(live[k]);
      tot = (seq.size() < LANES) ? seq.size() : LANES;
      for (int i = 0; i < tot; i++) begin
        ev[i] = 1'b1;
        et[i*TAG_W +: TAG_W] = seq[i];
      end
      pops = (q.size() < LANES) ? q.size() : LANES;
    end
    chk(out_valid == ev, req, "out_valid", 64'(out_valid), 64'(ev));
    chk((out_tag & {{TAG_W{ev[3]}}, {TAG_W{ev[2]}}, {TAG_W{ev[1]}}, {TAG_W{ev[0]}}}) == et,
        req, "out_tag", 64'(out_tag), 64'(et));
    if (exp_cnt >= 0) chk($countones(out_valid) == exp_cnt, req, "forward count",
                          64'($countones(out_valid)), 64'(exp_cnt));
    chk(skid_full == ((DEPTH - q.size()) < LANES), "R8", "skid_full",
        64'(skid_full), 64'((DEPTH - q.size()) < LANES));
    chk(ovf_err == merr, "R9", "ovf_err", 64'(ovf_err), 64'(merr));
    // advance model
    if (fl) begin
      q.delete();
    end else begin
      taken = tot - pops;
      for (int i = 0; i < pops; i++) void'(q.pop_front());
      room = DEPTH - q.size();
      for (int k = (st ? 0 : taken); k < live.size(); k++) begin
        if (room > 0) begin q.push_back(live[k]); room--; end
        else merr = 1;
      end
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    // R1: reset state with idle input
    #23;
    chk(out_valid == '0, "R1", "out_valid in reset", 64'(out_valid), 0);
    chk(skid_full == 1'b0, "R1", "skid_full in reset", 64'(skid_full), 0);
    chk(ovf_err == 1'b0, "R1", "ovf_err in reset", 64'(ovf_err), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    step(0, 0, 4'b0000, 4'b0000, 8'h00, 0, "R1");

    // vector table
    for (int n = 0; n < 10; n++) begin
      logic [20:0] e;
      e = VEC[n];
      step(e[20], e[19], e[18:15], e[14:11], e[10:3], int'(e[2:0]), req_of(n));
    end

    // R8 / R9: fill by stalling, then clip
    step(1, 0, 4'b1111, 4'b0000, 8'hA0, 0, "R6");
    step(1, 0, 4'b1111, 4'b0000, 8'hA4, 0, "R6");
    step(1, 0, 4'b1111, 4'b0000, 8'hA8, 0, "R8");
    step(1, 0, 4'b0011, 4'b0000, 8'hB0, 0, "R8");
    step(1, 0, 4'b1111, 4'b0000, 8'hC0, 0, "R9");
    for (int n = 0; n < 4; n++) step(0, 0, 4'b0000, 4'b0000, 8'h00, 4, "R9");
    step(0, 0, 4'b0000, 4'b0000, 8'h00, 0, "R9");

    // R7: flush empties, error stays
    step(1, 0, 4'b1111, 4'b0000, 8'hD0, 0, "R6");
    step(0, 1, 4'b1111, 4'b0000, 8'hE0, 0, "R7");
    step(0, 0, 4'b0000, 4'b0000, 8'h00, 0, "R7");
    step(0, 0, 4'b0001, 4'b0000, 8'hF0, 1, "R7");

    // R1: second reset clears the sticky flag
    @(posedge clk); #1;
    rst_n = 1'b0; in_valid = '0; in_squash = '0; stall = 0; flush = 0;
    q.delete(); merr = 0;
    #12;
    chk(ovf_err == 1'b0, "R1", "ovf_err after reset", 64'(ovf_err), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    step(0, 0, 4'b0000, 4'b0000, 8'h00, 0, "R1");

    finish_run();
  end

endmodule